// File: doc/BRIEF.md
# Comparator Output Conditioning and Interrupt

This block is the digital back end behind one analog comparator. The comparator's raw decision is an asynchronous single bit. The block brings it into the peripheral clock domain through a two-flop synchronizer and can complement it. It then runs the value through a programmable persistence filter. The filter changes its output only after the new level has been seen on 1 to 64 consecutive filter samples, counted in powers of two. A prescaler can slow the sample rate to every second or every fourth clock.

The external output pin carries either the raw synchronized level or the filtered level. A programmable edge detector watches the conditioned level. When it sees an edge of the chosen kind, it sets a sticky interrupt flag, and it sets a sticky wake flag when wake is enabled. Both flags are cleared by write-one strobes. All comparator levels are forced low while the block is disabled. Disabling also clears the synchronizer, the prescaler and the filter history.

Top module: `cmp_out_cond`

## Requirements
- R1: The raw input reaches `cmp_sync_o` through two clock registers: a change that is applied between edges k-1 and k shows on `cmp_sync_o` just after edge k+1.
- R2: When `invert_i` is 1, the synchronized level is complemented before it is filtered, selected and edge-detected.
- R3: Filter code 0 bypasses the filter, so `cmp_filt_o` equals `cmp_sync_o`. Codes 1 to 7 require 1, 2, 4, 8, 16, 32 and 64 consecutive differing samples before `cmp_filt_o` takes the new level. With the prescaler off, the change lands N edges after it lands on `cmp_sync_o`.
- R4: A level that differs from the filtered value for fewer than N samples leaves `cmp_filt_o` unchanged, and it raises no edge flag.
- R5: The divider code sets the sample rate. Code 0 samples every clock, code 1 every 2nd clock and code 2 every 4th clock. Code 3 behaves as code 0. With code 7 and code 2, the filter spans 256 clocks.
- R6: `out_sel_i` = 0 drives `cmp_out_o` from the synchronized level, and `out_sel_i` = 1 drives it from the filtered level.
- R7: The polarity code chooses which edges of the watched level set the interrupt flag. Code 0 selects both edges, code 1 rising only, code 2 falling only, and code 3 none. The watched level is the filtered one, which equals the synchronized one under code 0. The flag sets one edge after the watched level changes.
- R8: `irq_flag_o` stays set until `irq_clr_i` is high at a clock edge. If a new event and a clear fall on the same edge, the flag stays set.
- R9: `irq_o` is high exactly when `irq_flag_o` and `irq_en_i` are both high.
- R10: When `wake_en_i` is 1, each interrupt event also sets `wake_flag_o`, which is cleared by `wake_clr_i`. When `wake_en_i` is 0, events leave it untouched.
- R11: While `enable_i` is 0, `cmp_sync_o`, `cmp_filt_o` and `cmp_out_o` are 0 in the same cycle, and the drop to 0 raises no event. After re-enabling, the filter starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| enable_i | input | 1 | Block enable; 0 forces levels low and clears history |
| invert_i | input | 1 | Complement the synchronized level |
| out_sel_i | input | 1 | Output pin source: 0 synchronized, 1 filtered |
| filt_code_i | input | 3 | Filter length code: 0 off, k gives 2^(k-1) samples |
| fclk_div_i | input | 2 | Filter sample rate: 0 every clock, 1 every 2nd, 2 every 4th, 3 as 0 |
| edge_pol_i | input | 2 | Event edge: 0 both, 1 rising, 2 falling, 3 none |
| irq_en_i | input | 1 | Interrupt line enable |
| wake_en_i | input | 1 | Let events set the wake flag |
| irq_clr_i | input | 1 | Write-one strobe clearing the interrupt flag |
| wake_clr_i | input | 1 | Write-one strobe clearing the wake flag |
| cmp_sync_o | output | 1 | Synchronized, optionally inverted level |
| cmp_filt_o | output | 1 | Filtered level |
| cmp_out_o | output | 1 | Level driven to the output pin |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| wake_flag_o | output | 1 | Sticky wake flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times the filter exactly at 4 and 64 samples. A filter that is off by one count would move its output a clock early or late. Under the divider, the bench brackets the transition between its earliest and latest legal edge, because the prescaler phase is free-running. Code 3 must match code 0 exactly, and a design that decodes code 3 as a slow rate would be late. A short glitch must neither move the filtered level nor raise a flag, which catches a counter that fails to restart on a matching sample. The bench also lands a clear strobe on the same edge as a new event: a design where the clear wins would lose the flag. Dropping the enable with a high level must raise no falling-edge flag. After re-enabling, the full filter delay must be seen again, which catches stale history.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  typedef enum logic [1:0] {
    POL_ANY  = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_NONE = 2'b11
  } edge_pol_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  input  logic inv_i,
  output logic val_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (!en_i) sh_q <= '0;
    else            sh_q <= {sh_q[STAGES-2:0], raw_i};
  end

  assign val_o = en_i & (sh_q[STAGES-1] ^ inv_i);
endmodule

// File: rtl/cmp_filter.sv
module cmp_filter #(
  parameter int MAX_LOG2 = 6,
  parameter int CODE_W   = 3,
  parameter int DIV_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              smp_i,
  output logic              filt_o,
  output logic              tick_o
);
  localparam int CNT_W = MAX_LOG2 + 1;
  localparam int PRE_W = (1 << DIV_W) - 2;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [CNT_W-1:0] cnt_q, n_len, cnt_inc;
  logic             filt_q, tick;

  // reserved all-ones divider code maps to full rate
  always_comb begin
    pre_mask = '0;
    if (div_i != '1)
      for (int i = 0; i < PRE_W; i++)
        if (i < int'(div_i)) pre_mask[i] = 1'b1;
  end

  assign tick    = ((pre_q & pre_mask) == pre_mask);
  assign n_len   = (code_i == '0) ? CNT_W'(1) : (CNT_W'(1) << (code_i - CODE_W'(1)));
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0; cnt_q <= '0; filt_q <= 1'b0;
    end else if (!en_i) begin
      pre_q <= '0; cnt_q <= '0; filt_q <= 1'b0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (code_i == '0) begin
        filt_q <= smp_i;
        cnt_q  <= '0;
      end else if (tick) begin
        if (smp_i != filt_q) begin
          if (cnt_inc >= n_len) begin
            filt_q <= smp_i;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign filt_o = en_i & ((code_i == '0) ? smp_i : filt_q);
  assign tick_o = tick;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(1 << MAX_LOG2)); // R3
  AST_FILT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && code_i != '0 && $past(code_i) == code_i && filt_q != $past(filt_q))
      |-> $past(tick)); // R5
  AST_FILT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (filt_q == 1'b0 && cnt_q == '0)); // R11
endmodule

// File: rtl/cmp_edge_flags.sv
module cmp_edge_flags
  import cmp_cond_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       watch_i,
  input  logic [1:0] pol_i,
  input  logic       wake_en_i,
  input  logic       irq_clr_i,
  input  logic       wake_clr_i,
  output logic       irq_flag_o,
  output logic       wake_flag_o
);
  logic prev_q, rise, fall, evt, irq_q, wake_q;

  assign rise = watch_i & ~prev_q;
  assign fall = ~watch_i & prev_q;

  always_comb begin
    unique case (edge_pol_e'(pol_i))
      POL_ANY:  evt = rise | fall;
      POL_RISE: evt = rise;
      POL_FALL: evt = fall;
      default:  evt = 1'b0;
    endcase
    evt = evt & en_i;
  end

  // hardware set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0; irq_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      prev_q <= en_i & watch_i;
      irq_q  <= evt | (irq_q & ~irq_clr_i);
      wake_q <= (evt & wake_en_i) | (wake_q & ~wake_clr_i);
    end
  end

  assign irq_flag_o  = irq_q;
  assign wake_flag_o = wake_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && irq_clr_i) |=> irq_flag_o); // R8
  AST_RSVD_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == 2'b11 && !irq_flag_o) |=> !irq_flag_o); // R7
  AST_WAKE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_en_i && !wake_flag_o) |=> !wake_flag_o); // R10
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond #(
  parameter int MAX_LOG2 = 6,
  parameter int DIV_W    = 2,
  parameter int SYNC_N   = 2,
  localparam int CODE_W  = $clog2(MAX_LOG2 + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_raw_i,
  input  logic              enable_i,
  input  logic              invert_i,
  input  logic              out_sel_i,
  input  logic [CODE_W-1:0] filt_code_i,
  input  logic [DIV_W-1:0]  fclk_div_i,
  input  logic [1:0]        edge_pol_i,
  input  logic              irq_en_i,
  input  logic              wake_en_i,
  input  logic              irq_clr_i,
  input  logic              wake_clr_i,
  output logic              cmp_sync_o,
  output logic              cmp_filt_o,
  output logic              cmp_out_o,
  output logic              irq_flag_o,
  output logic              wake_flag_o,
  output logic              irq_o
);
  logic sync_val, filt_val, tick_unused;

  cmp_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i),
    .raw_i(cmp_raw_i), .inv_i(invert_i), .val_o(sync_val)
  );

  cmp_filter #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W), .DIV_W(DIV_W)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .code_i(filt_code_i),
    .div_i(fclk_div_i), .smp_i(sync_val), .filt_o(filt_val), .tick_o(tick_unused)
  );

  cmp_edge_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i), .watch_i(filt_val),
    .pol_i(edge_pol_i), .wake_en_i(wake_en_i), .irq_clr_i(irq_clr_i),
    .wake_clr_i(wake_clr_i), .irq_flag_o(irq_flag_o), .wake_flag_o(wake_flag_o)
  );

  assign cmp_sync_o = sync_val;
  assign cmp_filt_o = filt_val;
  assign cmp_out_o  = out_sel_i ? filt_val : sync_val;
  assign irq_o      = irq_flag_o & irq_en_i;

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && irq_flag_o)); // R9
  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!cmp_sync_o && !cmp_filt_o && !cmp_out_o)); // R11
  AST_SYNC_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i) && $past(enable_i, 2) && $past(rst_ni) && $past(rst_ni, 2))
      |-> (cmp_sync_o == ($past(cmp_raw_i, 2) ^ invert_i))); // R1
endmodule

// File: tb/sim_cmp_out_cond.sv
`timescale 1ns/1ps
module sim_cmp_out_cond;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmp_raw_i = 0, enable_i = 0, invert_i = 0, out_sel_i = 0;
  logic [2:0] filt_code_i = '0;
  logic [1:0] fclk_div_i = '0, edge_pol_i = '0;
  logic irq_en_i = 0, wake_en_i = 0, irq_clr_i = 0, wake_clr_i = 0;
  logic cmp_sync_o, cmp_filt_o, cmp_out_o, irq_flag_o, wake_flag_o, irq_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  cmp_out_cond u0 (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic clr_flags();
    irq_clr_i = 1; wake_clr_i = 1; step(1); irq_clr_i = 0; wake_clr_i = 0;
  endtask

  task automatic init(input logic [2:0] code, input logic [1:0] div,
                      input logic inv, input logic osel, input logic [1:0] pol);
    enable_i = 0; cmp_raw_i = 0; irq_en_i = 0; wake_en_i = 0;
    filt_code_i = code; fclk_div_i = div; invert_i = inv; out_sel_i = osel;
    edge_pol_i = pol;
    step(2); clr_flags();
    enable_i = 1; step(3); clr_flags();
  endtask

  task automatic t_reset();
    chk("R11 reset sync", cmp_sync_o, 0);
    chk("R11 reset out", cmp_out_o, 0);
    chk("R8 reset irq flag", irq_flag_o, 0);
    chk("R10 reset wake flag", wake_flag_o, 0);
    chk("R9 reset irq", irq_o, 0);
  endtask

  task automatic t_sync();
    init(3'd0, 2'd0, 0, 0, 2'd0);
    cmp_raw_i = 1; step(1);
    chk("R1 one edge", cmp_sync_o, 0);
    step(1);
    chk("R1 two edges", cmp_sync_o, 1);
    chk("R3 bypass", cmp_filt_o, 1);
  endtask

  task automatic t_invert();
    init(3'd0, 2'd0, 1, 0, 2'd0);
    chk("R2 inverted low", cmp_sync_o, 1);
    cmp_raw_i = 1; step(2);
    chk("R2 inverted high", cmp_sync_o, 0);
    chk("R2 out pin", cmp_out_o, 0);
  endtask

  task automatic t_filter();
    init(3'd3, 2'd0, 0, 1, 2'd0);
    cmp_raw_i = 1; step(5);
    chk("R3 N4 early", cmp_filt_o, 0);
    chk("R6 pin filtered early", cmp_out_o, 0);
    step(1);
    chk("R3 N4 on time", cmp_filt_o, 1);
    chk("R6 pin filtered", cmp_out_o, 1);
    init(3'd7, 2'd0, 0, 1, 2'd0);
    cmp_raw_i = 1; step(65);
    chk("R3 N64 early", cmp_filt_o, 0);
    step(1);
    chk("R3 N64 on time", cmp_filt_o, 1);
  endtask

  task automatic t_glitch();
    init(3'd3, 2'd0, 0, 1, 2'd0);
    cmp_raw_i = 1; step(3); cmp_raw_i = 0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (cmp_filt_o !== 1'b0) chk("R4 glitch filt", cmp_filt_o, 0);
    end
    chk("R4 glitch filt end", cmp_filt_o, 0);
    chk("R4 glitch no flag", irq_flag_o, 0);
  endtask

  task automatic t_div();
    init(3'd3, 2'd1, 0, 1, 2'd0);
    cmp_raw_i = 1; step(8);
    chk("R5 div2 early", cmp_filt_o, 0);
    step(2);
    chk("R5 div2 late", cmp_filt_o, 1);
    init(3'd3, 2'd3, 0, 1, 2'd0);
    cmp_raw_i = 1; step(5);
    chk("R5 code3 early", cmp_filt_o, 0);
    step(1);
    chk("R5 code3 as full rate", cmp_filt_o, 1);
    init(3'd7, 2'd2, 0, 1, 2'd0);
    cmp_raw_i = 1; step(254);
    chk("R5 256 span early", cmp_filt_o, 0);
    step(4);
    chk("R5 256 span late", cmp_filt_o, 1);
  endtask

  task automatic t_outsel();
    init(3'd3, 2'd0, 0, 0, 2'd0);
    cmp_raw_i = 1; step(2);
    chk("R6 pin unfiltered", cmp_out_o, 1);
    chk("R6 filt still low", cmp_filt_o, 0);
  endtask

  task automatic t_pol();
    init(3'd0, 2'd0, 0, 0, 2'd1);
    cmp_raw_i = 1; step(2);
    chk("R7 rise not yet", irq_flag_o, 0);
    step(1);
    chk("R7 rise sets", irq_flag_o, 1);
    clr_flags(); cmp_raw_i = 0; step(4);
    chk("R7 rise ignores fall", irq_flag_o, 0);
    init(3'd0, 2'd0, 0, 0, 2'd2);
    cmp_raw_i = 1; step(4);
    chk("R7 fall ignores rise", irq_flag_o, 0);
    cmp_raw_i = 0; step(3);
    chk("R7 fall sets", irq_flag_o, 1);
    init(3'd0, 2'd0, 0, 0, 2'd0);
    cmp_raw_i = 1; step(3);
    chk("R7 any rise", irq_flag_o, 1);
    clr_flags(); cmp_raw_i = 0; step(3);
    chk("R7 any fall", irq_flag_o, 1);
    init(3'd0, 2'd0, 0, 0, 2'd3);
    cmp_raw_i = 1; step(4); cmp_raw_i = 0; step(4);
    chk("R7 reserved none", irq_flag_o, 0);
    init(3'd2, 2'd0, 0, 0, 2'd1);
    cmp_raw_i = 1; step(3);
    chk("R7 watches filtered early", irq_flag_o, 0);
    step(2);
    chk("R7 watches filtered", irq_flag_o, 1);
  endtask

  task automatic t_sticky();
    init(3'd0, 2'd0, 0, 0, 2'd0);
    cmp_raw_i = 1; step(3);
    cmp_raw_i = 0; step(4);
    chk("R8 sticky", irq_flag_o, 1);
    chk("R9 gated off", irq_o, 0);
    irq_en_i = 1; #1;
    chk("R9 gated on", irq_o, 1);
    clr_flags();
    chk("R8 cleared", irq_flag_o, 0);
    chk("R9 follows flag", irq_o, 0);
    cmp_raw_i = 1; step(2); irq_clr_i = 1; step(1); irq_clr_i = 0;
    chk("R8 set wins", irq_flag_o, 1);
  endtask

  task automatic t_wake();
    init(3'd0, 2'd0, 0, 0, 2'd0);
    cmp_raw_i = 1; step(3);
    chk("R10 wake off", wake_flag_o, 0);
    wake_en_i = 1; cmp_raw_i = 0; step(3);
    chk("R10 wake set", wake_flag_o, 1);
    wake_clr_i = 1; step(1); wake_clr_i = 0;
    chk("R10 wake clear", wake_flag_o, 0);
    chk("R10 irq flag kept", irq_flag_o, 1);
  endtask

  task automatic t_disable();
    init(3'd3, 2'd0, 0, 1, 2'd0);
    cmp_raw_i = 1; step(8);
    chk("R11 setup filt high", cmp_filt_o, 1);
    clr_flags();
    enable_i = 0; #1;
    chk("R11 sync low", cmp_sync_o, 0);
    chk("R11 filt low", cmp_filt_o, 0);
    chk("R11 out low", cmp_out_o, 0);
    step(3);
    chk("R11 no flag on disable", irq_flag_o, 0);
    enable_i = 1; step(5);
    chk("R11 filter restarted", cmp_filt_o, 0);
    step(1);
    chk("R11 filter refilled", cmp_filt_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1; step(1);
    t_reset();
    t_sync();
    t_invert();
    t_filter();
    t_glitch();
    t_div();
    t_outsel();
    t_pol();
    t_sticky();
    t_wake();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule